// File: doc/BRIEF.md
# Early-out signed multiplier

A sequential two's-complement multiplier whose run time depends on the operand values. On a start strobe it takes a multiplicand and a multiplier at one of three operand widths: a quarter, half or all of `XLEN`, which is 8, 16 or 32 bits by default. It forms the exact double-width product with a shift-and-add loop over the multiplier's magnitude. The loop stops as soon as no significant multiplier bits remain. The completion strobe then fires at a latency set by the magnitude of the multiplier, whatever its sign. A flag adds a fixed penalty when the multiplier arrived from memory.

Two results are returned. The first is the full product, which is always exact. The second is a single-width truncation, for forms that keep only the low half. One flag reports that the product does not survive truncation to the operand width.

Top module: `early_out_mul`

## Requirements
- R1: While `rst_ni` is low, `done_o`, `ovf_o`, `prod_o` and `trunc_o` are all zero.
- R2: `size_i` selects the operand width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 gives 32 bits. Only the low bits of `mcand_i` and `mplier_i` at that width are used, read as two's complement. The bits above them have no effect on any output.
- R3: `prod_o` holds the exact signed product of the two operands, sign-extended to 64 bits. This holds for every operand pair, the most negative values included.
- R4: Let m be a nonzero multiplier with `mem_op_i` low. `done_o` rises exactly L clock edges after the edge that accepts the start, where L = max(ceil(log2|m|), 3) + 6. A negative m uses its magnitude.
- R5: A zero multiplier with `mem_op_i` low gives L = 9.
- R6: When `mem_op_i` is high at the start, L grows by 3 over the values in R4 and R5.
- R7: `done_o` is high for exactly one cycle per operation. `prod_o`, `trunc_o` and `ovf_o` change only in the cycle in which `done_o` is high, and hold their values until the next completion.
- R8: `ovf_o` is 0 when `prod_o` equals the sign extension of its low operand-width bits. Otherwise it is 1.
- R9: `trunc_o` is the low operand-width bits of the product, sign-extended to 32 bits.
- R10: A start arriving while an operation is in progress is ignored. This includes the edge on which that operation completes. The running result and its timing are unchanged, and no extra completion is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; operands sampled on the accepting edge |
| size_i | input | 2 | Operand width select (0: 8, 1: 16, 2/3: 32) |
| mem_op_i | input | 1 | Multiplier came from memory; adds 3 cycles |
| mcand_i | input | 32 | Multiplicand |
| mplier_i | input | 32 | Multiplier |
| done_o | output | 1 | One-cycle completion strobe |
| prod_o | output | 64 | Double-width signed product |
| trunc_o | output | 32 | Single-width truncated product, sign-extended |
| ovf_o | output | 1 | Product does not fit the operand width |

## Verification
A zero multiplier and multipliers of magnitude 1, 8 and 9 separate the fixed floor of the latency formula from its logarithmic part. Paired positive and negative multipliers of the same magnitude show that the timing follows the magnitude rather than the raw bits. The most negative operands at each width, and products just inside or outside the operand width, exercise the exact product, the truncation and the overflow flag. Garbage in the unused upper operand bits, a start raised mid-operation, and several hundred random operations at all widths with and without the memory penalty complete the stimulus. A behavioural model predicts the cycle of every completion and every output value.

// File: rtl/eom_pkg.sv
package eom_pkg;

  typedef enum logic [1:0] {
    SZ_QUARTER = 2'd0,
    SZ_HALF    = 2'd1,
    SZ_FULL    = 2'd2,
    SZ_FULL_B  = 2'd3
  } eom_size_e;

  function automatic int unsigned width_of(eom_size_e s, int unsigned xlen);
    case (s)
      SZ_QUARTER: return xlen / 4;
      SZ_HALF:    return xlen / 2;
      default:    return xlen;
    endcase
  endfunction

endpackage

// File: rtl/eom_latency.sv
module eom_latency #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned BASE_CYC  = 6,
  parameter int unsigned MIN_STEPS = 3,
  parameter int unsigned MEM_CYC   = 3,
  parameter int unsigned ZERO_CYC  = 9,
  parameter int unsigned LAT_W     = 6
) (
  input  logic [XLEN-1:0]  mag_i,
  input  logic             mem_i,
  output logic [LAT_W-1:0] lat_o
);

  logic [XLEN-1:0]  mag_m1;
  logic [LAT_W-1:0] clog;
  logic [LAT_W-1:0] steps;
  logic [LAT_W-1:0] core;

  // ceil(log2(x)) == bit length of (x-1) for x >= 1
  always_comb begin
    mag_m1 = mag_i - XLEN'(1);
    clog   = '0;
    for (int i = 0; i < XLEN; i++) begin
      if (mag_m1[i]) clog = LAT_W'(i + 1);
    end
    steps = (clog < LAT_W'(MIN_STEPS)) ? LAT_W'(MIN_STEPS) : clog;
    core  = (mag_i == '0) ? LAT_W'(ZERO_CYC) : steps + LAT_W'(BASE_CYC);
    lat_o = mem_i ? core + LAT_W'(MEM_CYC) : core;
  end

endmodule

// File: rtl/eom_ctrl.sv
module eom_ctrl #(
  parameter int unsigned LAT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o,
  output logic             fire_o
);

  logic [LAT_W-1:0] left_q;

  assign accept_o = start_i & ~busy_o;
  assign last_o   = busy_o & (left_q == LAT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      left_q <= '0;
      fire_o <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (accept_o) begin
        busy_o <= 1'b1;
        left_q <= lat_i;
      end else if (last_o) begin
        busy_o <= 1'b0;
        fire_o <= 1'b1;
      end else if (busy_o) begin
        left_q <= left_q - LAT_W'(1);
      end
    end
  end

endmodule

// File: rtl/eom_datapath.sv
module eom_datapath #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned PW  = 2 * XLEN
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic signed [XLEN-1:0] a_i,
  input  logic signed [XLEN-1:0] b_i,
  output logic signed [PW-1:0]   prod_o
);

  logic [XLEN-1:0] mag_a, mag_b;
  logic [PW-1:0]   sh_a, acc;
  logic [XLEN-1:0] rem_b;
  logic            neg_q;

  assign mag_a = a_i[XLEN-1] ? -a_i : a_i;
  assign mag_b = b_i[XLEN-1] ? -b_i : b_i;

  // one multiplier bit per cycle; stops once no set bits remain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_a  <= '0;
      acc   <= '0;
      rem_b <= '0;
      neg_q <= 1'b0;
    end else if (load_i) begin
      sh_a  <= PW'(mag_a);
      acc   <= '0;
      rem_b <= mag_b;
      neg_q <= a_i[XLEN-1] ^ b_i[XLEN-1];
    end else if (rem_b != '0) begin
      if (rem_b[0]) acc <= acc + sh_a;
      sh_a  <= sh_a << 1;
      rem_b <= rem_b >> 1;
    end
  end

  assign prod_o = neg_q ? -$signed(acc) : $signed(acc);

endmodule

// File: rtl/early_out_mul.sv
module early_out_mul
  import eom_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned BASE_CYC  = 6,
  parameter int unsigned MIN_STEPS = 3,
  parameter int unsigned MEM_CYC   = 3,
  parameter int unsigned ZERO_CYC  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        size_i,
  input  logic              mem_op_i,
  input  logic [XLEN-1:0]   mcand_i,
  input  logic [XLEN-1:0]   mplier_i,
  output logic              done_o,
  output logic [2*XLEN-1:0] prod_o,
  output logic [XLEN-1:0]   trunc_o,
  output logic              ovf_o
);

  localparam int unsigned PW      = 2 * XLEN;
  localparam int unsigned MAX_LAT = (XLEN - 1) + BASE_CYC + MEM_CYC + ZERO_CYC;
  localparam int unsigned LAT_W   = $clog2(MAX_LAT + 1);

  eom_size_e               size_e, size_q;
  int unsigned             op_sh, res_sh;
  logic [XLEN-1:0]         a_sh, b_sh;
  logic signed [XLEN-1:0]  a_ext, b_ext;
  logic [XLEN-1:0]         mag_b;
  logic [LAT_W-1:0]        lat;
  logic                    accept, busy, last, fire;
  logic signed [PW-1:0]    dp_prod, low_ext;
  logic [PW-1:0]           dp_sh;

  assign size_e = eom_size_e'(size_i);

  // operand sign extension from the selected width
  always_comb begin
    op_sh = XLEN - width_of(size_e, XLEN);
    a_sh  = mcand_i << op_sh;
    b_sh  = mplier_i << op_sh;
    a_ext = $signed(a_sh) >>> op_sh;
    b_ext = $signed(b_sh) >>> op_sh;
    mag_b = b_ext[XLEN-1] ? -b_ext : b_ext;
  end

  eom_latency #(
    .XLEN(XLEN), .BASE_CYC(BASE_CYC), .MIN_STEPS(MIN_STEPS),
    .MEM_CYC(MEM_CYC), .ZERO_CYC(ZERO_CYC), .LAT_W(LAT_W)
  ) u_lat (
    .mag_i(mag_b), .mem_i(mem_op_i), .lat_o(lat)
  );

  eom_ctrl #(.LAT_W(LAT_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .lat_i(lat),
    .accept_o(accept), .busy_o(busy), .last_o(last), .fire_o(fire)
  );

  eom_datapath #(.XLEN(XLEN)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept),
    .a_i(a_ext), .b_i(b_ext), .prod_o(dp_prod)
  );

  // truncation and fit test at the width latched with the operands
  always_comb begin
    res_sh  = PW - width_of(size_q, XLEN);
    dp_sh   = dp_prod << res_sh;
    low_ext = $signed(dp_sh) >>> res_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q  <= SZ_QUARTER;
      prod_o  <= '0;
      trunc_o <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (accept) size_q <= size_e;
      if (last) begin
        prod_o  <= dp_prod;
        trunc_o <= low_ext[XLEN-1:0];
        ovf_o   <= (low_ext != dp_prod);
      end
    end
  end

  assign done_o = fire;

endmodule

// File: rtl/eom_checker.sv
module eom_checker #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned MIN_LAT = 9,
  parameter int unsigned MAX_LAT = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_i,
  input logic              done_i,
  input logic [2*XLEN-1:0] prod_i,
  input logic [XLEN-1:0]   trunc_i,
  input logic              ovf_i
);

  logic [15:0] wait_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wait_cnt <= '0;
    else if (start_i && !busy_i) wait_cnt <= '0;
    else if (busy_i)             wait_cnt <= wait_cnt + 16'd1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> ($stable(prod_i) && $stable(trunc_i) && $stable(ovf_i))); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_i |-> (prod_i == {{XLEN{trunc_i[XLEN-1]}}, trunc_i})); // R8

  AST_LAT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (wait_cnt >= 16'(MIN_LAT) && wait_cnt <= 16'(MAX_LAT))); // R4

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!busy_i && $past(busy_i))); // R10

endmodule

bind early_out_mul eom_checker #(
  .XLEN(XLEN),
  .MIN_LAT((ZERO_CYC < MIN_STEPS + BASE_CYC) ? ZERO_CYC : MIN_STEPS + BASE_CYC),
  .MAX_LAT(((XLEN - 1 + BASE_CYC) > ZERO_CYC ? (XLEN - 1 + BASE_CYC) : ZERO_CYC) + MEM_CYC)
) u_eom_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_i(busy),
  .done_i(done_o), .prod_i(prod_o), .trunc_i(trunc_o), .ovf_i(ovf_o)
);

// File: tb/early_out_mul_test.sv
module early_out_mul_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  size;
  logic        mem_op;
  logic [31:0] mcand, mplier;
  logic        done;
  logic [63:0] prod;
  logic [31:0] trunc;
  logic        ovf;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  string tag  = "R1";

  // reference model state
  bit          m_busy;
  int          m_left;
  longint      m_prod;
  bit          e_done;
  logic [63:0] e_prod;
  logic [31:0] e_trunc;
  bit          e_ovf;

  always #2 clk = ~clk;

  early_out_mul uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size),
    .mem_op_i(mem_op), .mcand_i(mcand), .mplier_i(mplier),
    .done_o(done), .prod_o(prod), .trunc_o(trunc), .ovf_o(ovf)
  );

  function automatic int wbits(logic [1:0] s);
    return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
  endfunction

  function automatic longint sx(longint v, int w);
    longint r;
    r = v & ((64'sd1 <<< w) - 1);
    if (r[w-1]) r = r - (64'sd1 <<< w);
    return r;
  endfunction

  function automatic int model_lat(longint b, bit mem);
    longint mag;
    int k;
    mag = (b < 0) ? -b : b;
    if (mag == 0) k = 9;
    else begin
      k = 0;
      while ((64'sd1 <<< k) < mag) k++;
      k = ((k < 3) ? 3 : k) + 6;
    end
    return mem ? k + 3 : k;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_left = 0; e_done = 0;
      e_prod = '0; e_trunc = '0; e_ovf = 0;
    end else begin
      e_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          longint t;
          int w;
          m_busy = 0;
          e_done = 1;
          w = wbits(size_at_start);
          t = sx(m_prod, w);
          e_prod  = m_prod;
          e_trunc = t[31:0];
          e_ovf   = (t != m_prod);
        end
      end else if (start) begin
        longint a, b;
        a = sx(longint'(mcand), wbits(size));
        b = sx(longint'(mplier), wbits(size));
        size_at_start = size;
        m_prod = a * b;
        m_left = model_lat(b, mem_op);
        m_busy = 1;
      end
    end
  end
  logic [1:0] size_at_start;

  always @(negedge clk) begin
    bit bad;
    bad = 0;
    vectors++;
    if (done !== e_done) begin
      bad = 1;
      $display("FAIL %s R7 done: got %0b exp %0b (latency R4/R5/R6)", tag, done, e_done);
    end
    if (prod !== e_prod) begin
      bad = 1;
      $display("FAIL %s R3 prod: got %h exp %h", tag, prod, e_prod);
    end
    if (trunc !== e_trunc) begin
      bad = 1;
      $display("FAIL %s R9 trunc: got %h exp %h", tag, trunc, e_trunc);
    end
    if (ovf !== e_ovf) begin
      bad = 1;
      $display("FAIL %s R8 ovf: got %0b exp %0b", tag, ovf, e_ovf);
    end
    if (bad) errors++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(logic [1:0] s, logic [31:0] a, logic [31:0] b, bit mem);
    @(negedge clk);
    size = s; mcand = a; mplier = b; mem_op = mem; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mcand = $urandom; mplier = $urandom; size = 2'($urandom); mem_op = 1'($urandom);
    wait_idle();
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; size = '0; mem_op = 1'b0;
    mcand = '0; mplier = '0; size_at_start = '0;
    tag = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    tag = "R5";
    run_op(2'd0, 32'd3, 32'd0, 0);          // 9 cycles
    tag = "R6";
    run_op(2'd0, 32'd3, 32'd0, 1);          // 12 cycles
    run_op(2'd1, 32'd77, 32'd9, 1);         // 13 cycles
    tag = "R4";
    run_op(2'd0, 32'd5, 32'd1, 0);          // floor: 9
    run_op(2'd0, 32'd5, 32'd8, 0);          // 9
    run_op(2'd0, 32'd5, 32'd9, 0);          // 10
    run_op(2'd0, 32'd5, 32'hFFFFFFF7, 0);   // -9: 10
    run_op(2'd0, 32'hF9, 32'h80, 0);        // -7 * -128: 13, ovf
    run_op(2'd2, 32'h80000000, 32'h80000000, 1); // 40
    tag = "R3";
    run_op(2'd1, 32'd300, 32'hFED4, 0);     // 300 * -300
    run_op(2'd1, 32'h8000, 32'h8000, 0);
    run_op(2'd2, 32'h7FFFFFFF, 32'd2, 0);
    run_op(2'd3, 32'd1, 32'hFFFFFFFF, 0);
    tag = "R8";
    run_op(2'd0, 32'd127, 32'd127, 0);      // ovf
    run_op(2'd0, 32'd10, 32'hFD, 0);        // -30, fits
    run_op(2'd0, 32'hF0, 32'd8, 0);         // -128, fits
    tag = "R9";
    run_op(2'd1, 32'h1234, 32'h0100, 0);
    tag = "R2";
    run_op(2'd0, 32'hABCDEF05, 32'h123456FD, 0); // 5 * -3
    run_op(2'd1, 32'hFFFF0003, 32'h7777FFFE, 1); // 3 * -2

    tag = "R10";
    @(negedge clk);
    size = 2'd1; mcand = 32'd1000; mplier = 32'd4000; mem_op = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    size = 2'd0; mcand = 32'd7; mplier = 32'd0; start = 1'b1;  // ignored
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
    wait_idle();

    tag = "R7";
    for (int i = 0; i < 400; i++) begin
      run_op(2'($urandom), $urandom, (i % 3 == 0) ? ($urandom >> ($urandom % 32)) : $urandom,
             1'($urandom));
    end

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule